// File: doc/BRIEF.md
# PCI-to-ISA Interrupt Steering Router

This block takes the four shared PCI interrupt lines (A, B, C and D) and three auxiliary interrupt inputs and presents them as a 16-line ISA IRQ vector. Each source owns a 4-bit steering field. The field value is the IRQ number that the source drives. A field value of zero leaves the source disconnected. When several sources name the same IRQ, the output line is the OR of all of them. A polarity byte decides, for each PCI line, whether it is taken as active-high or as inverted. The auxiliary inputs are always active-high.

Software programs five byte registers through a byte-wide configuration write port. A combinational read port returns the stored bytes. All interrupt inputs pass through a two-stage synchronizer. The IRQ vector is combinational from the registers and the synchronized inputs, so a legacy interrupt controller can sample it directly.

The block contains no sequencing logic, so it has no state machine. Its state is the register bank and the synchronizer flops.

Top module: `irq_steer_router`

## Requirements
- R1: After reset, all five steering/polarity registers read back 0x00 and `isa_irq_out` is all zeros whatever the inputs are.
- R2: Register 0x56 bits [7:4] steer PCI line A (`pci_irq_in[0]`), and bits [3:0] steer PCI line B (`pci_irq_in[1]`).
- R3: Register 0x55 bits [7:4] steer PCI line D (`pci_irq_in[3]`), and bits [3:0] steer auxiliary input 0 (`aux_irq_in[0]`).
- R4: Register 0x57 bits [7:4] steer PCI line C (`pci_irq_in[2]`), and bits [3:0] steer auxiliary input 1 (`aux_irq_in[1]`).
- R5: Register 0x58 bits [3:0] steer auxiliary input 2 (`aux_irq_in[2]`). Bits [7:4] of this register are stored but route nothing.
- R6: A steering value of 0 disconnects its source. A value n from 1 to 15 drives `isa_irq_out[n]`. `isa_irq_out[0]` is never asserted.
- R7: Register 0x54 bits 3, 2, 1 and 0 set the polarity of PCI lines A, B, C and D. A set bit passes the line through unchanged. A clear bit inverts it. The auxiliary inputs are never inverted.
- R8: Each output line is the OR of every active source that is steered to that IRQ number.
- R9: A read at addresses 0x54 to 0x58 returns the last byte written there. A read at any other address returns 0x00. Writes to other addresses change nothing.
- R10: A write takes effect at the clock edge that samples it. An input change reaches `isa_irq_out` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address (read and write) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| pci_irq_in | input | 4 | PCI interrupt lines, bit 0 = A through bit 3 = D |
| aux_irq_in | input | 3 | Auxiliary interrupt inputs 0 to 2 |
| isa_irq_out | output | 16 | Steered ISA IRQ vector, bit n = IRQ n |

## Verification
The read data is due in the same cycle as the address. A register write shows on the IRQ vector right after the edge that samples it. An input change shows only after the second rising edge. The bench drives every input on the falling edge and samples on a later falling edge. Random trials wait three edges before comparing against a model of the register bank. One directed case samples after one edge and again after two, so that both the old and the new vector are checked against the two-edge latency.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int NUM_PCI   = 4;
    localparam int NUM_AUX   = 3;
    localparam int NUM_SRC   = NUM_PCI + NUM_AUX;
    localparam int IRQ_LINES = 16;
    localparam int SEL_W     = $clog2(IRQ_LINES);
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NUM_REGS  = 5;
    localparam logic [ADDR_W-1:0] REG_BASE = 8'h54;

    // Source order used for route vectors.
    typedef enum logic [2:0] {
        SRC_PA = 3'd0,
        SRC_PB = 3'd1,
        SRC_PC = 3'd2,
        SRC_PD = 3'd3,
        SRC_X0 = 3'd4,
        SRC_X1 = 3'd5,
        SRC_X2 = 3'd6
    } src_e;

    // Register bank slots (address = REG_BASE + slot).
    typedef enum logic [2:0] {
        SLOT_POL = 3'd0,
        SLOT_DX0 = 3'd1,
        SLOT_AB  = 3'd2,
        SLOT_CX1 = 3'd3,
        SLOT_X2  = 3'd4
    } slot_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                if (s == 0) stage_q[s] <= d;
                else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/steer_regs.sv
module steer_regs
    import irq_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_PCI-1:0] pol_pass,
    output logic [NUM_SRC-1:0][SEL_W-1:0] route
);
    logic [DATA_W-1:0] bank_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_BASE + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        bank_q[i] <= '0;
            else if (we && (addr == MY_ADDR))  bank_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(REG_BASE + i)) rdata = bank_q[i];
        end
    end

    // Polarity byte: bit 3 = A ... bit 0 = D.
    for (genvar p = 0; p < NUM_PCI; p++) begin : g_pol
        assign pol_pass[p] = bank_q[SLOT_POL][NUM_PCI-1-p];
    end

    assign route[SRC_PA] = bank_q[SLOT_AB][7:4];
    assign route[SRC_PB] = bank_q[SLOT_AB][3:0];
    assign route[SRC_PC] = bank_q[SLOT_CX1][7:4];
    assign route[SRC_PD] = bank_q[SLOT_DX0][7:4];
    assign route[SRC_X0] = bank_q[SLOT_DX0][3:0];
    assign route[SRC_X1] = bank_q[SLOT_CX1][3:0];
    assign route[SRC_X2] = bank_q[SLOT_X2][3:0];
endmodule

// File: rtl/steer_decode.sv
module steer_decode #(
    parameter int LINES = 16,
    localparam int SW   = $clog2(LINES)
) (
    input  logic             active,
    input  logic [SW-1:0]    sel,
    output logic [LINES-1:0] hit
);
    assign hit[0] = 1'b0;
    for (genvar n = 1; n < LINES; n++) begin : g_line
        assign hit[n] = active && (sel == SW'(n));
    end
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_steer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [NUM_PCI-1:0]   pci_irq_in,
    input  logic [NUM_AUX-1:0]   aux_irq_in,
    output logic [IRQ_LINES-1:0] isa_irq_out
);
    logic [NUM_SRC-1:0]            raw_sync;
    logic [NUM_SRC-1:0]            src_active;
    logic [NUM_PCI-1:0]            pol_pass;
    logic [NUM_SRC-1:0][SEL_W-1:0] route;
    logic [IRQ_LINES-1:0]          hits [NUM_SRC];

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({aux_irq_in, pci_irq_in}),
        .q     (raw_sync)
    );

    steer_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .pol_pass (pol_pass),
        .route    (route)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (s < NUM_PCI) begin : g_pci
            assign src_active[s] = raw_sync[s] ^ ~pol_pass[s];
        end else begin : g_aux
            assign src_active[s] = raw_sync[s];
        end
        steer_decode #(.LINES(IRQ_LINES)) u_dec (
            .active (src_active[s]),
            .sel    (route[s]),
            .hit    (hits[s])
        );
    end

    always_comb begin
        isa_irq_out = '0;
        for (int s = 0; s < NUM_SRC; s++) isa_irq_out |= hits[s];
    end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
    import irq_steer_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [ADDR_W-1:0]    cfg_addr,
    input logic [DATA_W-1:0]    cfg_wdata,
    input logic [DATA_W-1:0]    cfg_rdata,
    input logic [IRQ_LINES-1:0] isa_irq_out
);
    logic mapped;
    logic wrote_q;

    assign mapped = (cfg_addr >= REG_BASE) && (cfg_addr < ADDR_W'(REG_BASE + NUM_REGS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                wrote_q <= 1'b0;
        else if (cfg_we && mapped) wrote_q <= 1'b1;
    end

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrote_q |-> (isa_irq_out == '0));

    // R6
    irq0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_irq_out[0]);

    // R8
    fanin_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isa_irq_out) <= NUM_SRC);

    // R9
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && mapped) |=> ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata))));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (cfg_rdata == '0));
endmodule

bind irq_steer_router irq_steer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .isa_irq_out (isa_irq_out)
);

// File: tb/irq_steer_router_tb.sv
module irq_steer_router_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pci_irq_in = 4'h0;
    logic [2:0]  aux_irq_in = 3'h0;
    logic [15:0] isa_irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] sh [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_steer_router u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pci_irq_in(pci_irq_in),
        .aux_irq_in(aux_irq_in), .isa_irq_out(isa_irq_out)
    );

    function automatic logic [15:0] model(logic [3:0] p, logic [2:0] x);
        logic [15:0] v = '0;
        logic [3:0]  r [7];
        logic [6:0]  act;
        r[0] = sh[2][7:4]; r[1] = sh[2][3:0]; r[2] = sh[3][7:4]; r[3] = sh[1][7:4];
        r[4] = sh[1][3:0]; r[5] = sh[3][3:0]; r[6] = sh[4][3:0];
        for (int i = 0; i < 4; i++) act[i] = sh[0][3-i] ? p[i] : ~p[i];
        for (int i = 0; i < 3; i++) act[4+i] = x[i];
        for (int i = 0; i < 7; i++) if (act[i] && r[i] != 0) v[r[i]] = 1'b1;
        return v;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 8'h54 && a <= 8'h58) sh[a - 8'h54] = d;
    endtask

    task automatic drive(logic [3:0] p, logic [2:0] x);
        pci_irq_in = p; aux_irq_in = x;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
        cfg_addr = a;
        #1;
        chk(req, {8'h00, cfg_rdata}, {8'h00, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 5; i++) sh[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 5; i++) rd("R1", 8'(8'h54 + i), 8'h00);
        drive(4'hF, 3'h7); chk("R1", isa_irq_out, 16'h0000);
        drive(4'h0, 3'h0); chk("R1", isa_irq_out, 16'h0000);

        // R2 line A / B with pass-through polarity
        wr(8'h54, 8'h0F); wr(8'h56, 8'h5A);
        drive(4'b0001, 3'h0); chk("R2", isa_irq_out, 16'h0020);
        drive(4'b0010, 3'h0); chk("R2", isa_irq_out, 16'h0400);
        // R3 line D / aux 0
        wr(8'h55, 8'hC3);
        drive(4'b1000, 3'b001); chk("R3", isa_irq_out, 16'h1008);
        // R4 line C / aux 1
        wr(8'h57, 8'h7E);
        drive(4'b0100, 3'b010); chk("R4", isa_irq_out, 16'h4080);
        // R5 aux 2, high nibble inert
        wr(8'h58, 8'hF2);
        drive(4'h0, 3'b100); chk("R5", isa_irq_out, 16'h0004);
        rd("R5", 8'h58, 8'hF2);
        // R6 zero disconnects, IRQ0 never driven
        wr(8'h56, 8'h00);
        drive(4'b0011, 3'h0); chk("R6", isa_irq_out, 16'h0000);
        chk("R6", {15'h0, isa_irq_out[0]}, 16'h0000);
        // R7 clear polarity bit inverts
        wr(8'h56, 8'h90); wr(8'h54, 8'h07);
        drive(4'b0000, 3'h0); chk("R7", isa_irq_out, model(4'b0000, 3'h0));
        chk("R7", {15'h0, isa_irq_out[9]}, 16'h0001);
        drive(4'b0001, 3'h0); chk("R7", {15'h0, isa_irq_out[9]}, 16'h0000);
        // R8 sharing
        wr(8'h54, 8'h0F); wr(8'h55, 8'h99); wr(8'h56, 8'h99); wr(8'h57, 8'h99); wr(8'h58, 8'h09);
        drive(4'b0000, 3'b010); chk("R8", isa_irq_out, 16'h0200);
        drive(4'b1000, 3'b000); chk("R8", isa_irq_out, 16'h0200);
        drive(4'b0000, 3'b000); chk("R8", isa_irq_out, 16'h0000);
        // R9 unmapped writes ignored, reads zero
        wr(8'h53, 8'hFF); wr(8'h59, 8'h11);
        rd("R9", 8'h53, 8'h00); rd("R9", 8'h59, 8'h00); rd("R9", 8'h56, 8'h99);
        drive(4'h0, 3'h0); chk("R9", isa_irq_out, 16'h0000);
        // R10 latency: inputs two edges, writes one edge
        wr(8'h56, 8'hB0);
        pci_irq_in = 4'b0001;
        @(negedge clk); chk("R10", isa_irq_out, 16'h0000);
        @(negedge clk); chk("R10", isa_irq_out, 16'h0800);
        wr(8'h56, 8'hD0); chk("R10", isa_irq_out, 16'h2000);

        // Random trials
        for (int t = 0; t < 400; t++) begin
            logic [7:0] a;
            a = ($urandom % 8 == 0) ? 8'($urandom) : 8'(8'h54 + ($urandom % 5));
            wr(a, 8'($urandom));
            drive(4'($urandom), 3'($urandom));
            chk("R8", isa_irq_out, model(pci_irq_in, aux_irq_in));
            begin
                int k = $urandom % 5;
                rd("R9", 8'(8'h54 + k), sh[k]);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule